// File: doc/BRIEF.md
# I2C SCL Split-Phase Clock Generator

This block derives the serial clock of an I2C master from the peripheral clock. A single configuration word carries two divider fields, one sizing the low half of SCL and one sizing the high half. Each phase lasts eight clocks times its field plus one, so the duty cycle can be asymmetric. The bit engine uses single-cycle strobes at each SCL edge and at the middle of each phase. It changes SDA at the low-phase midpoint and samples SDA at the high-phase midpoint.

A small state machine sequences the clock. Its states are `SCL_IDLE` (disabled, SCL high), `SCL_LOW` and `SCL_HIGH`. It has these transitions:
- `SCL_IDLE -> SCL_LOW` when enabled.
- `SCL_LOW -> SCL_HIGH` when the low count ends.
- `SCL_HIGH -> SCL_LOW` when the high count ends.
- any state `-> SCL_LOW` at count zero on a restart strobe.
- any state `-> SCL_IDLE` when the enable drops.

The divider fields are captured only on entry to `SCL_LOW`. A reprogrammed word therefore never truncates a phase that is already running.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is asserted or `en` is low, `scl` is 1 and all four strobes are 0, and the block stays quiet for as long as `en` stays low.
- R2: Each low phase of `scl` lasts 8 × (low field + 1) clock cycles.
- R3: Each high phase of `scl` lasts 8 × (high field + 1) clock cycles.
- R4: Both fields come from `cfg_div`: the low-phase field is bits [DIV_W-1:0] and the high-phase field is bits [2·DIV_W-1:DIV_W].
- R5: With both fields zero, the SCL period is 16 clock cycles (8 low, 8 high).
- R6: A change of `cfg_div` takes effect only from the next low-phase start. The phase in progress and the high phase that follows it keep the previously captured values.
- R7: `restart` with `en` high starts a fresh low phase at count zero on the next cycle, from any state, and that low phase has its full length.
- R8: `low_mid_stb` is high for one cycle at offset 4 × (low field + 1) into each low phase. `high_mid_stb` is high for one cycle at offset 4 × (high field + 1) into each high phase. Offset 0 is the phase's first cycle.
- R9: `fall_stb` is high exactly in the first cycle of each low phase. `rise_stb` is high exactly in the first cycle of each high phase. At most one strobe is high in any cycle.
- R10: When `en` rises, the first low phase begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables clock generation; low forces idle |
| cfg_div | input | 2*DIV_W | Configuration word: low field in the lower half, high field in the upper half |
| restart | input | 1 | One-cycle request to begin a fresh low phase |
| scl | output | 1 | Generated SCL level |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| low_mid_stb | output | 1 | Middle of a low phase (SDA update point) |
| high_mid_stb | output | 1 | Middle of a high phase (SDA sample point) |

## Verification
The embedded assertions check on every cycle that:
- a disabled block leaves SCL high;
- a restart lands in a low phase at count zero;
- SCL never falls without the falling-edge strobe, and the strobes never overlap;
- the high field stays stable across a high phase;
- the counter stays inside the current phase's bound.

Only the bench scenarios can show the exact phase lengths and midpoint offsets for particular field values. The same holds for the 16-cycle fastest period, the position of each field in the word, and the rule that a mid-phase reprogramming waits for the next low-phase start.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    typedef enum logic [1:0] {
        SCL_IDLE = 2'd0,
        SCL_LOW  = 2'd1,
        SCL_HIGH = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_div_latch.sv
module scl_div_latch #(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [2*DIV_W-1:0] cfg_word,
    output logic [DIV_W-1:0]   divl_q,
    output logic [DIV_W-1:0]   divh_q
);
    // Capture both fields together so a phase pair always uses one word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divl_q <= '0;
            divh_q <= '0;
        end else if (load) begin
            divl_q <= cfg_word[DIV_W-1:0];
            divh_q <= cfg_word[2*DIV_W-1:DIV_W];
        end
    end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import i2c_scl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [2*DIV_W-1:0] cfg_div,
    input  logic               restart,
    output logic               scl,
    output logic               fall_stb,
    output logic               rise_stb,
    output logic               low_mid_stb,
    output logic               high_mid_stb
);
    // Phase length is (div+1)*8, so the counter needs three extra bits.
    localparam int CNT_W = DIV_W + 3;

    scl_state_e       state_q, state_d;
    logic [DIV_W-1:0] divl_q, divh_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lo_term, hi_term, lo_mid, hi_mid;
    logic             enter_phase, load_div, cnt_clr;

    scl_div_latch #(.DIV_W(DIV_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_div),
        .cfg_word (cfg_div),
        .divl_q   (divl_q),
        .divh_q   (divh_q)
    );

    scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    // Last count of a phase: div*8 + 7. Midpoint: (div+1)*4.
    always_comb begin
        lo_term = {divl_q, 3'b111};
        hi_term = {divh_q, 3'b111};
        lo_mid  = {({1'b0, divl_q} + {{DIV_W{1'b0}}, 1'b1}), 2'b00};
        hi_mid  = {({1'b0, divh_q} + {{DIV_W{1'b0}}, 1'b1}), 2'b00};
    end

    // Next-state process.
    always_comb begin
        state_d     = state_q;
        enter_phase = 1'b0;
        if (!en) begin
            state_d = SCL_IDLE;
        end else if (restart) begin
            state_d     = SCL_LOW;
            enter_phase = 1'b1;
        end else begin
            unique case (state_q)
                SCL_IDLE: begin
                    state_d     = SCL_LOW;
                    enter_phase = 1'b1;
                end
                SCL_LOW: begin
                    if (cnt == lo_term) begin
                        state_d     = SCL_HIGH;
                        enter_phase = 1'b1;
                    end
                end
                SCL_HIGH: begin
                    if (cnt == hi_term) begin
                        state_d     = SCL_LOW;
                        enter_phase = 1'b1;
                    end
                end
                default: begin
                    state_d     = SCL_IDLE;
                    enter_phase = 1'b0;
                end
            endcase
        end
        load_div = enter_phase && (state_d == SCL_LOW);
        cnt_clr  = !en || enter_phase;
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCL_IDLE;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb begin
        scl          = 1'b1;
        fall_stb     = 1'b0;
        rise_stb     = 1'b0;
        low_mid_stb  = 1'b0;
        high_mid_stb = 1'b0;
        unique case (state_q)
            SCL_IDLE: scl = 1'b1;
            SCL_LOW: begin
                scl         = 1'b0;
                fall_stb    = (cnt == '0);
                low_mid_stb = (cnt == lo_mid);
            end
            SCL_HIGH: begin
                scl          = 1'b1;
                rise_stb     = (cnt == '0);
                high_mid_stb = (cnt == hi_mid);
            end
            default: scl = 1'b1;
        endcase
    end

    // Disabled block leaves SCL high.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl && !fall_stb && !rise_stb && !low_mid_stb && !high_mid_stb));

    // Counter stays within the active phase's bound.
    p_low_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCL_LOW) |-> (cnt <= lo_term));
    p_high_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCL_HIGH) |-> (cnt <= hi_term));

    // High field is held through a high phase.
    p_divh_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCL_HIGH && $past(state_q) == SCL_HIGH) |-> $stable(divh_q));

    // Restart yields a fresh low phase.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart) |=> (fall_stb && !scl));

    // Strobes exclusive; an SCL fall is always marked.
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb, low_mid_stb, high_mid_stb}));
    p_fall_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> fall_stb);
endmodule

// File: tb/i2c_scl_gen_test.sv
module i2c_scl_gen_test;
    localparam int DIV_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic [2*DIV_W-1:0] cfg_div = '0;
    logic               restart = 1'b0;
    logic               scl, fall_stb, rise_stb, low_mid_stb, high_mid_stb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    i2c_scl_gen #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .restart(restart),
        .scl(scl), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .low_mid_stb(low_mid_stb), .high_mid_stb(high_mid_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int strobes();
        return {28'd0, fall_stb, rise_stb, low_mid_stb, high_mid_stb};
    endfunction

    // Align to a fall_stb cycle, then measure one low and one high phase.
    task automatic measure(output int lo, output int hi, output int lm, output int hm);
        lo = 0; hi = 0; lm = -1; hm = -1;
        while (!fall_stb) @(negedge clk);
        while (scl == 1'b0) begin
            if (low_mid_stb) lm = lo;
            lo++;
            @(negedge clk);
        end
        while (scl == 1'b1 && !fall_stb) begin
            if (high_mid_stb) hm = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 scl in reset", scl, 1);
        check("R1 strobes in reset", strobes(), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 scl disabled", scl, 1);
        check("R1 strobes disabled", strobes(), 0);
    endtask

    task automatic t_enable_asym();
        int lo, hi, lm, hm;
        cfg_div = {8'd5, 8'd2};
        en = 1'b1;
        @(negedge clk);
        check("R10 scl low after enable", scl, 0);
        check("R9 fall_stb first low cycle", fall_stb, 1);
        measure(lo, hi, lm, hm);
        check("R2 low length", lo, 24);
        check("R3 high length", hi, 48);
        check("R8 low mid offset", lm, 12);
        check("R8 high mid offset", hm, 24);
    endtask

    task automatic t_rise_strobe();
        while (!rise_stb) @(negedge clk);
        check("R9 scl high at rise_stb", scl, 1);
        @(negedge clk);
        check("R9 rise_stb one cycle", rise_stb, 0);
    endtask

    task automatic t_field_order();
        int lo, hi, lm, hm;
        cfg_div = {8'd1, 8'd3};
        measure(lo, hi, lm, hm);
        measure(lo, hi, lm, hm);
        check("R4 low field bits low half", lo, 32);
        check("R4 high field bits high half", hi, 16);
    endtask

    task automatic t_fastest();
        int lo, hi, lm, hm;
        cfg_div = 16'h0000;
        measure(lo, hi, lm, hm);
        measure(lo, hi, lm, hm);
        check("R5 period", lo + hi, 16);
        check("R5 low half", lo, 8);
        check("R8 mid offsets fast", lm + hm, 8);
    endtask

    task automatic t_change_mid();
        int lo, hi, lm, hm;
        cfg_div = {8'd1, 8'd1};
        measure(lo, hi, lm, hm);
        while (!fall_stb) @(negedge clk);
        @(negedge clk);
        cfg_div = {8'd0, 8'd3};
        lo = 1; hi = 0;
        while (scl == 1'b0) begin lo++; @(negedge clk); end
        while (scl == 1'b1 && !fall_stb) begin hi++; @(negedge clk); end
        check("R6 current low keeps old", lo, 16);
        check("R6 following high keeps old", hi, 16);
        measure(lo, hi, lm, hm);
        check("R6 new low applied", lo, 32);
        check("R6 new high applied", hi, 8);
    endtask

    task automatic t_restart();
        int lo, hi, lm, hm;
        cfg_div = {8'd2, 8'd2};
        measure(lo, hi, lm, hm);
        while (!fall_stb) @(negedge clk);
        repeat (5) @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        check("R7 fall_stb after restart in low", fall_stb, 1);
        measure(lo, hi, lm, hm);
        check("R7 full low after restart", lo, 24);
        while (!rise_stb) @(negedge clk);
        repeat (3) @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        check("R7 scl low after restart in high", scl, 0);
        check("R7 fall_stb after restart in high", fall_stb, 1);
    endtask

    task automatic t_disable();
        int bad = 0;
        repeat (7) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R1 scl high after disable", scl, 1);
        repeat (40) begin
            if (!scl || strobes() != 0) bad++;
            @(negedge clk);
        end
        check("R1 quiet while disabled", bad, 0);
        en = 1'b1;
        @(negedge clk);
        check("R10 low starts after re-enable", fall_stb, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_enable_asym();
                t_rise_strobe();
                t_field_order();
                t_fastest();
                t_change_mid();
                t_restart();
                t_disable();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual 1 expected 0");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule